// File: doc/BRIEF.md
# LCD Column Controller Command and RAM Port

This block is a slave model of the microprocessor port of one column controller in a dot-matrix LCD driver. A host addresses it with a chip select, a data/instruction select, a read/write direction and a one-cycle strobe. Each strobe is one of four transfers: a command write, a status read, a display-data write or a display-data read. Command writes load the page register, the column counter, the scan start line and the mode flags. Data transfers reach an internal byte-wide display RAM of 4 pages by 80 columns.

Reads go through an I/O latch. Each data read returns what the latch already held and then refills the latch from the addressed byte. After a new column address the host therefore issues one dummy read. A read-modify-write mode stops reads from moving the column, so a host can read a byte and write it back in place, for example to blink a cursor. Leaving the mode puts back the column that was current when the mode was entered.

The register values go out on plain outputs for a scan block. Read results appear on a registered read bus. Busy is modelled as a counter of a parameterised length. A hardware reset or any accepted command starts it.

Top module: `lcdc_port`

## Requirements
- R1: A strobe with `bus_sel`=1 is decoded from (`bus_dsel`,`bus_rd`): (1,1) is a data read, (1,0) is a data write, (0,1) is a status read and (0,0) is a command write. Read results appear on `bus_rdata` one clock after the strobe edge.
- R2: The command byte sets the register outputs as follows. AFh turns `disp_en` on and AEh turns it off. C0h+n sets `scan_top`=n (n in 0..31). B8h+p sets `page_ptr`=p (p in 0..3). Any byte from 00h to 4Fh loads `col_ptr` with that value. A1h/A0h set/clear `seg_flip`. A5h/A4h set/clear `all_lit`. A9h/A8h set/clear `duty_hi`. Unlisted codes change nothing.
- R3: The status byte has busy in bit 7, `seg_flip` in bit 6 and the inverse of `disp_en` in bit 5. Bit 4 is 1 while a reset is still in progress, and bits 3..0 are 0.
- R4: A hardware reset, or an accepted command, holds `busy` at 1 for BUSY_CYCLES clocks. While `busy` is 1, every transfer other than a status read is ignored.
- R5: Each accepted data read or write moves `col_ptr` up by one. The column stops at 80 and the page never changes. A write made while the column is 80 is dropped, and a read there refills the latch with 00h.
- R6: A data read returns the latch contents and then refills the latch from RAM[`page_ptr`][`col_ptr`]. The first read after a column change therefore returns the stale latch value.
- R7: Command E0h enters read-modify-write mode (`rmw_on`=1) and saves the column. In this mode reads keep the column, writes still advance it and set-column commands are ignored. EEh leaves the mode and restores the saved column.
- R8: The software reset command E2h sets `scan_top` to 0 and `page_ptr` to 3. It leaves the display RAM untouched and raises status bit 4 while busy.
- R9: A strobe with `bus_sel`=0 has no effect on any register, on the RAM or on `busy`.
- R10: After a hardware reset, `disp_en`, `seg_flip`, `all_lit`, `duty_hi` and `rmw_on` are all 0. Also `scan_top`=0, `col_ptr`=0, `page_ptr`=3 and the latch holds 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_dsel | input | 1 | 1 = data transfer, 0 = command/status |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_stb | input | 1 | One-cycle transfer strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte (status or data) |
| busy | output | 1 | Internal operation in progress |
| disp_en | output | 1 | Display enabled |
| scan_top | output | 5 | RAM line shown on the first row |
| page_ptr | output | 2 | Page used for host access |
| col_ptr | output | 7 | Column counter for host access |
| seg_flip | output | 1 | Reversed column-to-segment order |
| all_lit | output | 1 | Static drive mode |
| duty_hi | output | 1 | Full-height duty selected |
| rmw_on | output | 1 | Read-modify-write mode active |

## Verification
The hardest situation to reach is a stale latch that holds a meaningful, known value rather than the reset value. The stimulus gets there inside read-modify-write mode. It reads one byte twice, overwrites it and leaves the mode. It then expects the next read at the restored column to return the old byte, and the read after that to return the new one. Ignored transfers are produced by issuing a command or a data write in the clock right after an accepted command, while `busy` is still counting. Column saturation is driven by writing across the end of a page and reading back the bytes on each side.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CMD,
        OP_STAT,
        OP_WDATA,
        OP_RDATA
    } op_e;

    typedef enum logic [3:0] {
        C_NONE,
        C_ONOFF,
        C_START,
        C_PAGE,
        C_COL,
        C_FLIP,
        C_LIT,
        C_DUTY,
        C_RMW,
        C_END,
        C_RESET
    } cmd_e;

    localparam int STAT_BUSY_BIT  = 7;
    localparam int STAT_FLIP_BIT  = 6;
    localparam int STAT_OFF_BIT   = 5;
    localparam int STAT_RESET_BIT = 4;

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
#(
    parameter int COLS  = 80,
    parameter int PAGES = 4
) (
    input  logic       sel_i,
    input  logic       stb_i,
    input  logic       dsel_i,
    input  logic       rd_i,
    input  logic [7:0] byte_i,
    output op_e        op_o,
    output cmd_e       cmd_o
);

    always_comb begin
        op_o  = OP_NONE;
        cmd_o = C_NONE;
        if (sel_i && stb_i) begin
            unique case ({dsel_i, rd_i})
                2'b11:   op_o = OP_RDATA;
                2'b10:   op_o = OP_WDATA;
                2'b01:   op_o = OP_STAT;
                default: op_o = OP_CMD;
            endcase
        end
        if (op_o == OP_CMD) begin
            if (byte_i[7:1] == 7'b1010_111)                           cmd_o = C_ONOFF;
            else if (byte_i[7:5] == 3'b110)                           cmd_o = C_START;
            else if (byte_i[7:2] == 6'b1011_10 && 32'(byte_i[1:0]) < PAGES) cmd_o = C_PAGE;
            else if (32'(byte_i) < COLS)                              cmd_o = C_COL;
            else if (byte_i[7:1] == 7'b1010_000)                      cmd_o = C_FLIP;
            else if (byte_i[7:1] == 7'b1010_010)                      cmd_o = C_LIT;
            else if (byte_i[7:1] == 7'b1010_100)                      cmd_o = C_DUTY;
            else if (byte_i == 8'hE0)                                 cmd_o = C_RMW;
            else if (byte_i == 8'hEE)                                 cmd_o = C_END;
            else if (byte_i == 8'hE2)                                 cmd_o = C_RESET;
            else                                                      cmd_o = C_NONE;
        end
    end

    // R1: a decoded command class only exists for command writes
    always_comb begin
        if (op_o != OP_CMD) begin
            p_cmd_only_on_write_r1: assert (cmd_o == C_NONE);
        end
    end

endmodule

// File: rtl/lcdc_busy.sv
module lcdc_busy #(
    parameter int BUSY_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sw_reset_i,
    output logic busy_o,
    output logic resetting_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rflag;
    } bst_t;

    bst_t q, d;

    always_comb begin
        d = q;
        if (start_i) begin
            d.cnt   = CNT_W'(BUSY_CYCLES);
            d.rflag = sw_reset_i;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) d.rflag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt   <= CNT_W'(BUSY_CYCLES);
            q.rflag <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.cnt != '0);
    assign resetting_o = q.rflag;

    // R4: a new operation is only started when the counter is idle
    p_start_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // R4: an accepted command makes the block busy on the next clock
    p_start_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    // R8: reset-in-progress is only ever shown while busy
    p_reset_flag_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resetting_o |-> busy_o);

endmodule

// File: rtl/lcdc_ram.sv
module lcdc_ram #(
    parameter int PAGES = 4,
    parameter int COLS  = 80
) (
    input  logic                          clk,
    input  logic                          we_i,
    input  logic [$clog2(PAGES)-1:0]      page_i,
    input  logic [$clog2(COLS+1)-1:0]     col_i,
    input  logic [7:0]                    wdata_i,
    output logic [7:0]                    rdata_o
);

    localparam int DEPTH = PAGES * COLS;
    localparam int IDX_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic             in_range;

    assign in_range = (32'(col_i) < COLS);
    assign idx      = IDX_W'(32'(page_i) * COLS + 32'(col_i));

    always_ff @(posedge clk) begin
        if (we_i && in_range) mem[idx] <= wdata_i;
    end

    assign rdata_o = in_range ? mem[idx] : 8'h00;

    // R5: writers never address a column beyond the page
    p_write_in_page_r5: assert property (@(posedge clk) we_i |-> in_range);

endmodule

// File: rtl/lcdc_port.sv
module lcdc_port
    import lcdc_pkg::*;
#(
    parameter int PAGES       = 4,
    parameter int COLS        = 80,
    parameter int LINES       = 32,
    parameter int BUSY_CYCLES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_dsel,
    input  logic                       bus_rd,
    input  logic                       bus_stb,
    input  logic [7:0]                 bus_wdata,
    output logic [7:0]                 bus_rdata,
    output logic                       busy,
    output logic                       disp_en,
    output logic [$clog2(LINES)-1:0]   scan_top,
    output logic [$clog2(PAGES)-1:0]   page_ptr,
    output logic [$clog2(COLS+1)-1:0]  col_ptr,
    output logic                       seg_flip,
    output logic                       all_lit,
    output logic                       duty_hi,
    output logic                       rmw_on
);

    localparam int PG_W  = $clog2(PAGES);
    localparam int COL_W = $clog2(COLS + 1);
    localparam int LN_W  = $clog2(LINES);
    localparam logic [COL_W-1:0] COL_END = COL_W'(COLS);

    typedef struct packed {
        logic             disp_en;
        logic [LN_W-1:0]  start;
        logic [PG_W-1:0]  page;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] col_saved;
        logic             flip;
        logic             lit;
        logic             duty;
        logic             rmw;
        logic [7:0]       latch;
        logic [7:0]       rd;
    } st_t;

    st_t  q, d;
    op_e  op;
    cmd_e cmd;
    logic ram_we;
    logic [7:0] ram_rdata;
    logic accept;
    logic sw_rst;
    logic resetting;

    lcdc_decode #(.COLS(COLS), .PAGES(PAGES)) u_decode (
        .sel_i  (bus_sel),
        .stb_i  (bus_stb),
        .dsel_i (bus_dsel),
        .rd_i   (bus_rd),
        .byte_i (bus_wdata),
        .op_o   (op),
        .cmd_o  (cmd)
    );

    lcdc_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (accept),
        .sw_reset_i  (sw_rst),
        .busy_o      (busy),
        .resetting_o (resetting)
    );

    lcdc_ram #(.PAGES(PAGES), .COLS(COLS)) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .page_i  (q.page),
        .col_i   (q.col),
        .wdata_i (bus_wdata),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        d      = q;
        ram_we = 1'b0;
        accept = 1'b0;
        sw_rst = 1'b0;
        unique case (op)
            OP_STAT: begin
                d.rd = 8'h00;
                d.rd[STAT_BUSY_BIT]  = busy;
                d.rd[STAT_FLIP_BIT]  = q.flip;
                d.rd[STAT_OFF_BIT]   = ~q.disp_en;
                d.rd[STAT_RESET_BIT] = resetting;
            end
            OP_WDATA: begin
                if (!busy && q.col < COL_END) begin
                    ram_we = 1'b1;
                    d.col  = q.col + COL_W'(1);
                end
            end
            OP_RDATA: begin
                if (!busy) begin
                    d.rd    = q.latch;
                    d.latch = ram_rdata;
                    if (!q.rmw && q.col < COL_END) d.col = q.col + COL_W'(1);
                end
            end
            OP_CMD: begin
                if (!busy) begin
                    accept = 1'b1;
                    unique case (cmd)
                        C_ONOFF: d.disp_en = bus_wdata[0];
                        C_START: d.start   = bus_wdata[LN_W-1:0];
                        C_PAGE:  d.page    = bus_wdata[PG_W-1:0];
                        C_COL: begin
                            if (q.rmw) accept = 1'b0;
                            else       d.col  = bus_wdata[COL_W-1:0];
                        end
                        C_FLIP:  d.flip = bus_wdata[0];
                        C_LIT:   d.lit  = bus_wdata[0];
                        C_DUTY:  d.duty = bus_wdata[0];
                        C_RMW: begin
                            d.rmw       = 1'b1;
                            d.col_saved = q.col;
                        end
                        C_END: begin
                            if (q.rmw) begin
                                d.rmw = 1'b0;
                                d.col = q.col_saved;
                            end
                        end
                        C_RESET: begin
                            d.start = '0;
                            d.page  = PG_W'(PAGES - 1);
                            sw_rst  = 1'b1;
                        end
                        default: accept = 1'b0;
                    endcase
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.disp_en   <= 1'b0;
            q.start     <= '0;
            q.page      <= PG_W'(PAGES - 1);
            q.col       <= '0;
            q.col_saved <= '0;
            q.flip      <= 1'b0;
            q.lit       <= 1'b0;
            q.duty      <= 1'b0;
            q.rmw       <= 1'b0;
            q.latch     <= 8'h00;
            q.rd        <= 8'h00;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = q.rd;
    assign disp_en   = q.disp_en;
    assign scan_top  = q.start;
    assign page_ptr  = q.page;
    assign col_ptr   = q.col;
    assign seg_flip  = q.flip;
    assign all_lit   = q.lit;
    assign duty_hi   = q.duty;
    assign rmw_on    = q.rmw;

    // R5: the column counter never passes the end of the page
    p_col_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        col_ptr <= COL_END);
    // R4: transfers other than status reads are ignored while busy
    p_busy_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op != OP_STAT && op != OP_NONE) |=>
        ($stable(col_ptr) && $stable(page_ptr) && $stable(scan_top) && $stable(disp_en)));
    // R5: a write below the page end advances the column by one
    p_write_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op == OP_WDATA && col_ptr < COL_END) |=> col_ptr == $past(col_ptr) + COL_W'(1));
    // R7: reads in read-modify-write mode keep the column
    p_rmw_read_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op == OP_RDATA && rmw_on) |=> $stable(col_ptr));
    // R8: software reset lands on the top start line and the last page
    p_swreset_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op == OP_CMD && cmd == C_RESET) |=>
        (scan_top == '0 && page_ptr == PG_W'(PAGES - 1)));
    // R9: a deselected strobe leaves the busy counter alone
    p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && !busy) |=> !busy);

endmodule

// File: tb/lcdc_port_bench.sv
module lcdc_port_bench;

    localparam int BUSY = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_dsel = 1'b0, bus_rd = 1'b0, bus_stb = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       busy, disp_en, seg_flip, all_lit, duty_hi, rmw_on;
    logic [4:0] scan_top;
    logic [1:0] page_ptr;
    logic [6:0] col_ptr;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [7:0] val;
        bit         dc;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    lcdc_port #(.BUSY_CYCLES(BUSY)) u_lcdc_port (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_dsel(bus_dsel), .bus_rd(bus_rd), .bus_stb(bus_stb),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .disp_en(disp_en), .scan_top(scan_top), .page_ptr(page_ptr), .col_ptr(col_ptr),
        .seg_flip(seg_flip), .all_lit(all_lit), .duty_hi(duty_hi), .rmw_on(rmw_on)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(bit dsel, bit rd, logic [7:0] b, bit sel = 1'b1);
        @(negedge clk);
        bus_sel = sel; bus_dsel = dsel; bus_rd = rd; bus_wdata = b; bus_stb = 1'b1;
        @(negedge clk);
        bus_stb = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic cmd(logic [7:0] b);
        access(1'b0, 1'b0, b);
        wait_idle();
    endtask

    task automatic wr(logic [7:0] b);
        access(1'b1, 1'b0, b);
    endtask

    task automatic rd_exp(logic [7:0] e, string req, bit dc = 1'b0);
        item_t it;
        it.val = e; it.dc = dc; it.req = req;
        sb_q.push_back(it);
        access(1'b1, 1'b1, 8'h00);
    endtask

    task automatic st_exp(logic [7:0] e, string req);
        item_t it;
        it.val = e; it.dc = 1'b0; it.req = req;
        sb_q.push_back(it);
        access(1'b0, 1'b1, 8'h00);
    endtask

    // monitor: pops one expected byte for every read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && bus_sel && bus_stb && bus_rd) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    check("R1 unexpected read", 32'(bus_rdata), 32'hFFFF_FFFF);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    if (!it.dc) check(it.req, 32'(bus_rdata), 32'(it.val));
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10/R3: status during power-on busy: busy, display off, resetting
        st_exp(8'hB0, "R3 power-on status");
        wait_idle();
        check("R10 page after reset", 32'(page_ptr), 32'd3);
        check("R10 column after reset", 32'(col_ptr), 32'd0);
        check("R10 start after reset", 32'(scan_top), 32'd0);
        check("R10 flags after reset", {28'd0, disp_en, seg_flip, all_lit, rmw_on}, 32'd0);

        // R2/R4: display on, then measure busy length
        access(1'b0, 1'b0, 8'hAF);
        n = 0;
        while (busy) begin @(negedge clk); n++; end
        check("R4 busy length", 32'(n), 32'(BUSY));
        check("R2 display on", 32'(disp_en), 32'd1);
        st_exp(8'h00, "R3 idle status");

        // R4: commands and writes issued while busy are ignored
        access(1'b0, 1'b0, 8'hB8);
        access(1'b0, 1'b0, 8'hC5);
        wait_idle();
        check("R4 start ignored while busy", 32'(scan_top), 32'd0);
        check("R2 page set", 32'(page_ptr), 32'd0);
        access(1'b0, 1'b0, 8'h05);
        wr(8'h77);
        wait_idle();
        check("R4 write ignored while busy", 32'(col_ptr), 32'd5);

        // R2/R3: mode flags and their status bits
        cmd(8'hA1);
        st_exp(8'h40, "R3 flip bit");
        cmd(8'hA5);
        cmd(8'hA9);
        check("R2 static and duty", {30'd0, all_lit, duty_hi}, 32'd3);
        cmd(8'hAE);
        st_exp(8'h60, "R3 off bit");
        cmd(8'hAF);
        cmd(8'hD1);
        check("R2 start line 17", 32'(scan_top), 32'd17);
        cmd(8'h7F);
        check("R2 unlisted code ignored", 32'(col_ptr), 32'd5);

        // R5/R6: write three bytes and read them back through the latch
        cmd(8'hB9);
        cmd(8'h10);
        wr(8'h11); wr(8'h22); wr(8'h33);
        check("R5 column after writes", 32'(col_ptr), 32'h13);
        cmd(8'h10);
        rd_exp(8'h00, "R6 dummy read gives reset latch");
        rd_exp(8'h11, "R6 read 1");
        rd_exp(8'h22, "R6 read 2");
        rd_exp(8'h33, "R6 read 3");
        check("R5 column after reads", 32'(col_ptr), 32'h14);

        // R5: saturation at the end of the page
        cmd(8'h4E);
        wr(8'hAA); wr(8'hBB); wr(8'hCC);
        check("R5 column saturates", 32'(col_ptr), 32'd80);
        check("R5 page unchanged", 32'(page_ptr), 32'd1);
        cmd(8'h4E);
        rd_exp(8'h00, "R6 stale", 1'b1);
        rd_exp(8'hAA, "R5 byte 4Eh");
        rd_exp(8'hBB, "R5 byte 4Fh");
        rd_exp(8'h00, "R5 past end reads zero");
        check("R5 column held at end", 32'(col_ptr), 32'd80);

        // R7/R6: read-modify-write with a meaningful stale latch
        cmd(8'h10);
        cmd(8'hE0);
        check("R7 mode on", 32'(rmw_on), 32'd1);
        rd_exp(8'h00, "R6 stale", 1'b1);
        rd_exp(8'h11, "R7 read in place");
        check("R7 reads keep column", 32'(col_ptr), 32'h10);
        wr(8'h5C);
        check("R7 write advances", 32'(col_ptr), 32'h11);
        access(1'b0, 1'b0, 8'h30);
        check("R7 set-column not accepted", 32'(busy), 32'd0);
        check("R7 set-column ignored", 32'(col_ptr), 32'h11);
        cmd(8'hEE);
        check("R7 end restores column", 32'(col_ptr), 32'h10);
        check("R7 mode off", 32'(rmw_on), 32'd0);
        rd_exp(8'h11, "R6 stale latch after restore");
        rd_exp(8'h5C, "R7 modified byte");

        // R8: software reset
        cmd(8'hC3);
        cmd(8'hB8);
        access(1'b0, 1'b0, 8'hE2);
        st_exp(8'hD0, "R8 status during soft reset");
        wait_idle();
        check("R8 page three", 32'(page_ptr), 32'd3);
        check("R8 start zero", 32'(scan_top), 32'd0);
        check("R8 flags kept", {30'd0, disp_en, seg_flip}, 32'd3);
        cmd(8'hB9);
        cmd(8'h11);
        rd_exp(8'h00, "R6 stale", 1'b1);
        rd_exp(8'h22, "R8 RAM kept");

        // R9: deselected strobes do nothing
        access(1'b0, 1'b0, 8'hAE, 1'b0);
        check("R9 no busy when deselected", 32'(busy), 32'd0);
        check("R9 display unchanged", 32'(disp_en), 32'd1);
        access(1'b1, 1'b0, 8'h99, 1'b0);
        check("R9 column unchanged", 32'(col_ptr), 32'h13);

        // R10: hardware reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R10 busy after reset", 32'(busy), 32'd1);
        wait_idle();
        check("R10 flags cleared", {27'd0, disp_en, seg_flip, all_lit, duty_hi, rmw_on}, 32'd0);
        check("R10 page and column", {23'd0, page_ptr, col_ptr}, {23'd0, 2'd3, 7'd0});
        rd_exp(8'h00, "R10 latch cleared");

        repeat (4) @(negedge clk);
        check("R1 scoreboard drained", 32'(sb_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule